// File: doc/BRIEF.md
# Debug Run-Control Controller

This block sits next to a small processor core and decides, under debug, whether the core may execute. Debug events come in on a single pulse input. A configuration register sets what each event does. One halting mode stops the core hard. The other puts the core into a waiting state. From the waiting state an interrupt can still be vectored and serviced, and the block then returns to waiting. A trace trigger pulse fires for every debug event in every state. An external trace collector uses that pulse to keep instructions from before and after the event.

A host port (valid, opcode, data) replaces the path through a debug access port. Over this port the host can resume the core, step one instruction, halt the core, set or clear a timer-freeze flag, write the configuration and clear a sticky event flag. A read-data bus always shows the current state, the configuration and the sticky flag. The configuration can change only while the core runs.

Top module: `rc_run_ctrl`

## Requirements
- R1: With the halt flavour bit (data bit 0 of a configuration write) at 0 and the event action at HALT (code 0), a debug event while running moves the state to STOPPED (code 1) on the next edge, and `halt_o` is high from that edge.
- R2: From STOPPED or WAITING, opcode RUN (1) returns to RUNNING (code 0). Opcode STEP (2) enters STEPPING (code 4) with `halt_o` low. STEPPING waits for one `retire_i` pulse and then goes back to the state it came from, with `halt_o` high again.
- R3: With the halt flavour bit at 1, a HALT-action event while running moves the state to WAITING (code 2). In STOPPED, `irq_req_i` is ignored.
- R4: In WAITING, `irq_req_i` moves the state to SERVICING (code 3). In SERVICING, `irq_grant_o` is high and `halt_o` is low. `rfi_i` returns the state to WAITING on the next edge. If a RUN or STEP command arrives in the same cycle as an interrupt in WAITING, the command wins.
- R5: Every debug event, in any state, gives a one-cycle `trace_trig_o` pulse on the next edge.
- R6: The event action (configuration data bits 2:1) selects the outcome. Code 1 (EXC) gives a one-cycle `dbg_exc_o` pulse on the next edge while the core keeps running. Codes 2 and 3 only fire the trace trigger. While STOPPED or WAITING, an event changes no state and raises no exception.
- R7: Opcode CFG (5) loads the halt flavour and action only in RUNNING. In any other state it is ignored.
- R8: An event during STEPPING or SERVICING is latched. Its EXC action is issued as a `dbg_exc_o` pulse on the edge at which that excursion completes.
- R9: Opcode FRZ_SET (3) raises `tmr_freeze_o` and FRZ_CLR (4) lowers it. Run, stop, step and wait transitions leave it unchanged.
- R10: The read data is {sticky, 0, action[1:0], flavour, state[2:0]}. Each event sets the sticky flag. Opcode CLR (6) clears it, and an event in the same cycle wins over the clear.
- R11: Opcode HALT (7) while running enters STOPPED or WAITING according to the flavour. It does not set the sticky flag or fire the trace trigger.
- R12: Synchronous active-low reset gives RUNNING, flavour 0, action HALT, sticky 0 and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_evt_i | input | 1 | Debug event pulse |
| irq_req_i | input | 1 | Interrupt request from the core's interrupt logic |
| retire_i | input | 1 | Instruction-retired pulse from the core |
| rfi_i | input | 1 | Return-from-interrupt pulse from the core |
| host_valid_i | input | 1 | Host command strobe |
| host_op_i | input | 3 | Host opcode |
| host_data_i | input | DATA_W | Host write data (configuration) |
| host_rdata_o | output | DATA_W | Status and configuration read-back |
| halt_o | output | 1 | Core halt request |
| tmr_freeze_o | output | 1 | Timer freeze |
| irq_grant_o | output | 1 | Interrupt service grant |
| dbg_exc_o | output | 1 | Debug exception request pulse |
| trace_trig_o | output | 1 | Trace trigger pulse |

## Verification
Several rules are checked on every cycle: each event produces a trigger one edge later, and every trigger has an event behind it. The grant never coincides with halt, and STOPPED never grants. A completed step or interrupt return re-halts on the next edge. The freeze flag moves only on its own opcodes, and the configuration stays fixed outside RUNNING. Other behaviour needs the bench's scenarios. These are the exact status encodings along a long sequence, an exception deferred to the end of a step, the set-over-clear priority of the sticky flag, command-over-interrupt priority in WAITING, and the values after a reset mid-session.

// File: rtl/rc_pkg.sv
// Package: shared types for the run-control controller.
// Assumes: host opcodes and state codes are fixed encodings visible to the host.
package rc_pkg;
    localparam int RC_OP_W    = 3;
    localparam int RC_STATE_W = 3;
    localparam int RC_ACT_W   = 2;
    localparam int RC_STAT_W  = 8;

    typedef enum logic [RC_STATE_W-1:0] {
        RC_RUN  = 3'd0,
        RC_STOP = 3'd1,
        RC_WAIT = 3'd2,
        RC_SERV = 3'd3,
        RC_STEP = 3'd4
    } rc_state_e;

    typedef enum logic [RC_OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_RUN  = 3'd1,
        OP_STEP = 3'd2,
        OP_FSET = 3'd3,
        OP_FCLR = 3'd4,
        OP_CFG  = 3'd5,
        OP_CLR  = 3'd6,
        OP_HALT = 3'd7
    } rc_op_e;

    typedef enum logic [RC_ACT_W-1:0] {
        ACT_HALT  = 2'd0,
        ACT_EXC   = 2'd1,
        ACT_TRACE = 2'd2,
        ACT_TRC2  = 2'd3
    } rc_act_e;

    typedef struct packed {
        rc_act_e act;
        logic    wait_mode;
    } rc_cfg_t;

    typedef struct packed {
        logic run;
        logic step;
        logic halt;
        logic cfg_wr;
        logic frz_set;
        logic frz_clr;
        logic clr_sticky;
    } rc_cmd_t;
endpackage

// File: rtl/rc_host_decode.sv
// Module: host command decoder with the configuration and freeze registers.
// Assumes: one command per valid cycle; config writes are taken only while running.
module rc_host_decode
    import rc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid_i,
    input  logic [RC_OP_W-1:0] host_op_i,
    input  logic [DATA_W-1:0] host_data_i,
    input  rc_state_e         state_i,
    output rc_cmd_t           cmd_o,
    output rc_cfg_t           cfg_o,
    output logic              freeze_o
);
    rc_cfg_t cfg_q;
    logic    frz_q;
    rc_op_e  op;

    // Turn the opcode into one strobe per command.
    always_comb begin
        op    = rc_op_e'(host_op_i);
        cmd_o = '0;
        if (host_valid_i) begin
            unique case (op)
                OP_RUN:  cmd_o.run        = 1'b1;
                OP_STEP: cmd_o.step       = 1'b1;
                OP_HALT: cmd_o.halt       = 1'b1;
                OP_CFG:  cmd_o.cfg_wr     = 1'b1;
                OP_FSET: cmd_o.frz_set    = 1'b1;
                OP_FCLR: cmd_o.frz_clr    = 1'b1;
                OP_CLR:  cmd_o.clr_sticky = 1'b1;
                default: cmd_o            = '0;
            endcase
        end
    end

    // Configuration register, writable only while the core runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{act: ACT_HALT, wait_mode: 1'b0};
        end else if (cmd_o.cfg_wr && state_i == RC_RUN) begin
            cfg_q.wait_mode <= host_data_i[0];
            cfg_q.act       <= rc_act_e'(host_data_i[2:1]);
        end
    end

    // Timer freeze flag, changed only by its own commands.
    always_ff @(posedge clk) begin
        if (!rst_n)              frz_q <= 1'b0;
        else if (cmd_o.frz_set)  frz_q <= 1'b1;
        else if (cmd_o.frz_clr)  frz_q <= 1'b0;
    end

    assign cfg_o    = cfg_q;
    assign freeze_o = frz_q;
endmodule

// File: rtl/rc_event_unit.sv
// Module: debug event handling - trace trigger, exception pulse, pending latch, sticky flag.
// Assumes: excursion completion is a single-cycle strobe from the state controller.
module rc_event_unit
    import rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt_i,
    input  rc_state_e state_i,
    input  rc_cfg_t   cfg_i,
    input  logic      in_exc_i,
    input  logic      done_i,
    input  logic      clr_sticky_i,
    output logic      halt_req_o,
    output logic      trig_o,
    output logic      exc_o,
    output logic      sticky_o
);
    logic trig_q;
    logic exc_q;
    logic pend_q;
    logic sticky_q;
    logic is_run;
    logic exc_now;
    logic exc_late;

    // Decide what an event does right now and what a completed excursion releases.
    always_comb begin
        is_run     = (state_i == RC_RUN);
        halt_req_o = evt_i && is_run && (cfg_i.act == ACT_HALT);
        exc_now    = evt_i && is_run && (cfg_i.act == ACT_EXC);
        exc_late   = done_i && (pend_q || evt_i) && (cfg_i.act == ACT_EXC);
    end

    // Trigger and exception pulses, one cycle after their cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            exc_q  <= 1'b0;
        end else begin
            trig_q <= evt_i;
            exc_q  <= exc_now || exc_late;
        end
    end

    // Latch events seen during a step or interrupt excursion until it ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (done_i)             pend_q <= 1'b0;
        else if (evt_i && in_exc_i)  pend_q <= 1'b1;
    end

    // Sticky event flag; a new event beats a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             sticky_q <= 1'b0;
        else if (evt_i)         sticky_q <= 1'b1;
        else if (clr_sticky_i)  sticky_q <= 1'b0;
    end

    assign trig_o   = trig_q;
    assign exc_o    = exc_q;
    assign sticky_o = sticky_q;
endmodule

// File: rtl/rc_state_ctrl.sv
// Module: run/stop/wait/service/step state machine.
// Assumes: retire and return-from-interrupt are single-cycle pulses from the core.
module rc_state_ctrl
    import rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rc_cmd_t   cmd_i,
    input  rc_cfg_t   cfg_i,
    input  logic      evt_halt_i,
    input  logic      irq_i,
    input  logic      retire_i,
    input  logic      rfi_i,
    output rc_state_e state_o,
    output logic      in_exc_o,
    output logic      done_o
);
    rc_state_e state_q;
    rc_state_e state_d;
    logic      from_wait_q;
    logic      from_wait_d;

    // Next-state selection; host commands outrank interrupts in the wait state.
    always_comb begin
        state_d     = state_q;
        from_wait_d = from_wait_q;
        unique case (state_q)
            RC_RUN: begin
                if (evt_halt_i || cmd_i.halt)
                    state_d = cfg_i.wait_mode ? RC_WAIT : RC_STOP;
            end
            RC_STOP: begin
                if (cmd_i.run) begin
                    state_d = RC_RUN;
                end else if (cmd_i.step) begin
                    state_d     = RC_STEP;
                    from_wait_d = 1'b0;
                end
            end
            RC_WAIT: begin
                if (cmd_i.run) begin
                    state_d = RC_RUN;
                end else if (cmd_i.step) begin
                    state_d     = RC_STEP;
                    from_wait_d = 1'b1;
                end else if (irq_i) begin
                    state_d = RC_SERV;
                end
            end
            RC_SERV: begin
                if (rfi_i) state_d = RC_WAIT;
            end
            RC_STEP: begin
                if (retire_i) state_d = from_wait_q ? RC_WAIT : RC_STOP;
            end
            default: state_d = RC_RUN;
        endcase
    end

    // State and step-origin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RC_RUN;
            from_wait_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            from_wait_q <= from_wait_d;
        end
    end

    // Excursion flags for the event unit.
    always_comb begin
        in_exc_o = (state_q == RC_STEP) || (state_q == RC_SERV);
        done_o   = ((state_q == RC_STEP) && retire_i) || ((state_q == RC_SERV) && rfi_i);
    end

    assign state_o = state_q;
endmodule

// File: rtl/rc_run_ctrl.sv
// Module: top of the debug run-control controller.
// Assumes: DATA_W >= 8; inputs are synchronous to clk.
module rc_run_ctrl
    import rc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_evt_i,
    input  logic              irq_req_i,
    input  logic              retire_i,
    input  logic              rfi_i,
    input  logic              host_valid_i,
    input  logic [2:0]        host_op_i,
    input  logic [DATA_W-1:0] host_data_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              halt_o,
    output logic              tmr_freeze_o,
    output logic              irq_grant_o,
    output logic              dbg_exc_o,
    output logic              trace_trig_o
);
    rc_cmd_t   cmd;
    rc_cfg_t   cfg;
    rc_state_e state;
    logic      in_exc;
    logic      done;
    logic      halt_req;
    logic      sticky;
    logic [RC_STAT_W-1:0] stat;

    rc_host_decode #(.DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .host_valid_i(host_valid_i), .host_op_i(host_op_i), .host_data_i(host_data_i),
        .state_i(state), .cmd_o(cmd), .cfg_o(cfg), .freeze_o(tmr_freeze_o)
    );

    rc_state_ctrl u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cfg_i(cfg), .evt_halt_i(halt_req),
        .irq_i(irq_req_i), .retire_i(retire_i), .rfi_i(rfi_i),
        .state_o(state), .in_exc_o(in_exc), .done_o(done)
    );

    rc_event_unit u_evt (
        .clk(clk), .rst_n(rst_n), .evt_i(dbg_evt_i), .state_i(state), .cfg_i(cfg),
        .in_exc_i(in_exc), .done_i(done), .clr_sticky_i(cmd.clr_sticky),
        .halt_req_o(halt_req), .trig_o(trace_trig_o), .exc_o(dbg_exc_o), .sticky_o(sticky)
    );

    // Core-facing controls and the host read-back word.
    always_comb begin
        halt_o       = (state == RC_STOP) || (state == RC_WAIT);
        irq_grant_o  = (state == RC_SERV);
        stat         = {sticky, 1'b0, cfg.act, cfg.wait_mode, state};
        host_rdata_o = DATA_W'(stat);
    end
endmodule

// File: rtl/rc_run_ctrl_chk.sv
// Module: port-level property checker for rc_run_ctrl, attached by bind.
// Assumes: read-back word layout {sticky, 0, action, flavour, state}.
module rc_run_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_evt_i,
    input logic              irq_req_i,
    input logic              retire_i,
    input logic              rfi_i,
    input logic              host_valid_i,
    input logic [2:0]        host_op_i,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic              halt_o,
    input logic              tmr_freeze_o,
    input logic              irq_grant_o,
    input logic              dbg_exc_o,
    input logic              trace_trig_o
);
    p_evt_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt_i |=> trace_trig_o);
    p_trig_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_trig_o |-> $past(dbg_evt_i));
    p_grant_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant_o |-> !halt_o);
    p_rfi_rehalt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_grant_o && rfi_i) |=> (halt_o && !irq_grant_o));
    p_step_rehalt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata_o[2:0] == 3'd4 && retire_i) |=> halt_o);
    p_stop_noirq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata_o[2:0] == 3'd1) |-> !irq_grant_o);
    p_exc_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc_o |-> $past(dbg_evt_i || retire_i || rfi_i));
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata_o[2:0] != 3'd0) |=> $stable(host_rdata_o[5:3]));
    p_frz_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid_i && (host_op_i == 3'd3 || host_op_i == 3'd4)) |=> $stable(tmr_freeze_o));
endmodule

bind rc_run_ctrl rc_run_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .dbg_evt_i(dbg_evt_i), .irq_req_i(irq_req_i),
    .retire_i(retire_i), .rfi_i(rfi_i), .host_valid_i(host_valid_i), .host_op_i(host_op_i),
    .host_rdata_o(host_rdata_o), .halt_o(halt_o), .tmr_freeze_o(tmr_freeze_o),
    .irq_grant_o(irq_grant_o), .dbg_exc_o(dbg_exc_o), .trace_trig_o(trace_trig_o)
);

// File: tb/rc_run_ctrl_tb_top.sv
// Bench: vector table walked by one loop, then directed corner cases.
module rc_run_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int NVEC       = 24;

    typedef struct packed {
        logic       evt;
        logic       vld;
        logic [2:0] op;
        logic [7:0] dat;
        logic       irq;
        logic       ret;
        logic       rfi;
        logic       x_halt;
        logic       x_grant;
        logic       x_exc;
        logic       x_trig;
        logic       x_frz;
        logic [7:0] x_stat;
        logic [3:0] req;
    } vec_t;

    // Fields: evt vld op dat irq ret rfi | halt grant exc trig frz stat | requirement
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 4'd12}, // R12 idle
        '{1'b1,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0, 8'h81, 4'd1},  // R1 stop
        '{1'b0,1'b1,3'd5,8'h06,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h81, 4'd7},  // R7 cfg ignored
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h81, 4'd3},  // R3 irq ignored
        '{1'b0,1'b1,3'd2,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84, 4'd2},  // R2 step
        '{1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84, 4'd2},  // R2 wait retire
        '{1'b0,1'b0,3'd0,8'h00,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h81, 4'd2},  // R2 back to stop
        '{1'b0,1'b1,3'd6,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h01, 4'd10}, // R10 clear
        '{1'b0,1'b1,3'd3,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1, 8'h01, 4'd9},  // R9 freeze
        '{1'b0,1'b1,3'd1,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 4'd2},  // R2 run
        '{1'b0,1'b1,3'd5,8'h01,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'h08, 4'd7},  // R7 wait flavour
        '{1'b1,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b1, 8'h8A, 4'd3},  // R3 wait
        '{1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1, 8'h8B, 4'd4},  // R4 service
        '{1'b1,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b1, 8'h8B, 4'd8},  // R8 latch
        '{1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1, 8'h8A, 4'd4},  // R4 rfi
        '{1'b0,1'b1,3'd2,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'h8C, 4'd2},  // R2 step from wait
        '{1'b0,1'b0,3'd0,8'h00,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1, 8'h8A, 4'd2},  // R2 back to wait
        '{1'b0,1'b1,3'd1,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'h88, 4'd2},  // R2 run
        '{1'b0,1'b1,3'd5,8'h03,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'h98, 4'd7},  // R7 act exc
        '{1'b1,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1, 8'h98, 4'd6},  // R6 exception
        '{1'b0,1'b1,3'd4,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h98, 4'd9},  // R9 unfreeze
        '{1'b0,1'b1,3'd5,8'h04,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'hA0, 4'd7},  // R7 act trace
        '{1'b1,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'hA0, 4'd6},  // R6 trace only
        '{1'b0,1'b1,3'd6,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h20, 4'd10}  // R10 clear
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dbg_evt_i = 1'b0;
    logic              irq_req_i = 1'b0;
    logic              retire_i = 1'b0;
    logic              rfi_i = 1'b0;
    logic              host_valid_i = 1'b0;
    logic [2:0]        host_op_i = 3'd0;
    logic [DATA_W-1:0] host_data_i = '0;
    logic [DATA_W-1:0] host_rdata_o;
    logic              halt_o;
    logic              tmr_freeze_o;
    logic              irq_grant_o;
    logic              dbg_exc_o;
    logic              trace_trig_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_run_ctrl #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_evt_i(dbg_evt_i), .irq_req_i(irq_req_i),
        .retire_i(retire_i), .rfi_i(rfi_i), .host_valid_i(host_valid_i),
        .host_op_i(host_op_i), .host_data_i(host_data_i), .host_rdata_o(host_rdata_o),
        .halt_o(halt_o), .tmr_freeze_o(tmr_freeze_o), .irq_grant_o(irq_grant_o),
        .dbg_exc_o(dbg_exc_o), .trace_trig_o(trace_trig_o)
    );

    // Drive one cycle of inputs at the falling edge, then wait past the rising edge.
    task automatic apply(input logic evt, input logic vld, input logic [2:0] op,
                         input logic [7:0] dat, input logic irq, input logic ret, input logic rfi);
        @(negedge clk);
        dbg_evt_i    = evt;
        host_valid_i = vld;
        host_op_i    = op;
        host_data_i  = DATA_W'(dat);
        irq_req_i    = irq;
        retire_i     = ret;
        rfi_i        = rfi;
        @(posedge clk);
        #1;
    endtask

    // Compare all outputs against expected values; one check per call.
    task automatic check(input string tag, input logic xh, input logic xg, input logic xe,
                         input logic xt, input logic xf, input logic [7:0] xs);
        logic [12:0] act;
        logic [12:0] exp;
        act = {halt_o, irq_grant_o, dbg_exc_o, trace_trig_o, tmr_freeze_o, host_rdata_o[7:0]};
        exp = {xh, xg, xe, xt, xf, xs};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual halt/grant/exc/trig/frz/stat=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].evt, VEC[i].vld, VEC[i].op, VEC[i].dat, VEC[i].irq, VEC[i].ret, VEC[i].rfi);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].x_halt, VEC[i].x_grant,
                  VEC[i].x_exc, VEC[i].x_trig, VEC[i].x_frz, VEC[i].x_stat);
        end

        // R8: exception action deferred to the end of a step (host halt R11 first).
        apply(1'b0, 1'b1, 3'd5, 8'h02, 1'b0, 1'b0, 1'b0);
        check("R7 act exc flavour stop", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10);
        apply(1'b0, 1'b1, 3'd7, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R11 host halt", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
        apply(1'b0, 1'b1, 3'd2, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R2 step", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h14);
        apply(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R8 event in step", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h94);
        apply(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R8 exc at step end", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h91);
        apply(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R6 exc one cycle", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h91);

        // R10: event and clear together keep sticky; R6: no exception while stopped.
        apply(1'b1, 1'b1, 3'd6, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R10 set wins", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h91);

        // R4: command beats interrupt in the wait state.
        apply(1'b0, 1'b1, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R2 run", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h90);
        apply(1'b0, 1'b1, 3'd5, 8'h01, 1'b0, 1'b0, 1'b0);
        check("R7 cfg wait", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h88);
        apply(1'b0, 1'b1, 3'd7, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R11 halt to wait", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h8A);
        apply(1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R4 run beats irq", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h88);

        // R12: reset mid-session clears freeze and configuration.
        apply(1'b0, 1'b1, 3'd3, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R9 freeze set", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h88);
        @(negedge clk);
        rst_n = 1'b0;
        apply(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R12 reset again", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule